// File: doc/BRIEF.md
# CPU Extraction Word Stream Encoder

This block takes frames from a byte-wide source and presents them to a CPU as a sequence of 32-bit words. The CPU pulls these words one at a time through a read port. The source delivers the internal header first and then the frame bytes, FCS included. The encoder packs each group of four bytes into one data word. Framing is carried in-band with reserved status words of the form 0x8000000x:

- end of frame, carrying the count of unused bytes in the last data word;
- pruned;
- aborted;
- escape;
- not ready.

A small word queue separates the byte side from the read side. When the queue is full, the byte source is stalled through a ready signal. A configuration input selects byte-reversed data words for hosts of the other endianness. Status words are never reversed. The escape check looks at each data word exactly as it appears on the read port.

The CPU samples `rdData` and asserts `rdStrobe` for one cycle to consume the word on display. `dataPresent` tells the CPU that at least one unread word is queued.

Top module: `xtr_word_encoder`

## Requirements
- R1: After reset, `dataPresent` is low, `srcReady` is high and `rdData` shows the not-ready code 0x80000007.
- R2: Bytes are packed in arrival order, with the first byte of each group in bits 31:24 when `cfgSwap` is low. Each read consumes exactly one word, and the words appear in frame order.
- R3: A read while no word is queued returns 0x80000007 and consumes nothing. The first word queued afterwards is still delivered intact.
- R4: A normally ended frame (`srcLast` without `srcPrune`) delivers its last data word, zero-padded in unused byte lanes. That word is followed immediately by 0x80000000 | U, where U = 4 − (valid bytes in that word), taken modulo 4.
- R5: A data word whose presented value lies in 0x80000000..0x80000007 is preceded by the escape word 0x80000006.
- R6: A frame ended with `srcLast` and `srcPrune` together emits 0x80000004 in place of its final data word. Exactly one word follows it, holding the final group of up to 4 bytes. That word gets no escape, and no end-of-frame code follows it.
- R7: A beat with `srcAbort` discards its byte and any partly packed word, and emits 0x80000005. No further word follows for that frame. Complete words taken before the abort are still delivered.
- R8: With `cfgSwap` high, every data word is byte-reversed, so the first byte of a group sits in bits 7:0. Status words are not reversed. The escape check of R5 applies to the reversed value.
- R9: `dataPresent` is high exactly while an unread word remains, including the status and trailing words of a queued entry.
- R10: Once DEPTH word entries are queued, `srcReady` goes low and source beats stall until a read frees an entry. No byte is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcValid | input | 1 | Source beat valid |
| srcByte | input | 8 | Source byte |
| srcLast | input | 1 | Beat carries the last byte of the frame |
| srcPrune | input | 1 | With srcLast: end the frame as pruned |
| srcAbort | input | 1 | Abort the frame; this beat's byte is discarded |
| srcReady | output | 1 | Encoder can accept a beat |
| cfgSwap | input | 1 | Byte-reverse data words on the read port |
| rdStrobe | input | 1 | Consume the word currently on rdData |
| rdData | output | 32 | Current read word |
| dataPresent | output | 1 | At least one unread word is queued |

## Verification
Frames are fed whose lengths end on every byte lane. Each length shows a different unused-byte count in the end code and a different padding pattern. Some frames contain words that collide with the status codes, both with and without reversal. These separate an escape that tests the presented word from one that tests the raw word. Prune-ended and abort-ended frames check the trailing-word rules. Reads on an empty queue check that nothing is consumed. A frame longer than the queue, fed while the CPU reads, checks the source stall and lossless ordering.

// File: rtl/xtr_enc_pkg.sv
package xtr_enc_pkg;

  localparam logic [31:0] CODE_EOF    = 32'h8000_0000;
  localparam logic [31:0] CODE_PRUNED = 32'h8000_0004;
  localparam logic [31:0] CODE_ABORT  = 32'h8000_0005;
  localparam logic [31:0] CODE_ESC    = 32'h8000_0006;
  localparam logic [31:0] CODE_NOTRDY = 32'h8000_0007;

  typedef enum logic [1:0] {
    TK_DATA  = 2'd0,
    TK_LAST  = 2'd1,
    TK_PRUNE = 2'd2,
    TK_ABORT = 2'd3
  } tokKind_t;

  typedef struct packed {
    tokKind_t    kind;
    logic [1:0]  unused;
    logic [31:0] data;
  } token_t;

  typedef enum logic [2:0] {
    SEL_NOTRDY = 3'd0,
    SEL_DATA   = 3'd1,
    SEL_ESC    = 3'd2,
    SEL_EOF    = 3'd3,
    SEL_PRUNED = 3'd4,
    SEL_ABORT  = 3'd5
  } outSel_t;

  typedef struct packed {
    logic    pop;
    outSel_t sel;
  } ctrlStrobe_t;

endpackage

// File: rtl/xtr_enc_packer.sv
module xtr_enc_packer
  import xtr_enc_pkg::*;
#(
  parameter int WORD_BYTES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        srcValid,
  input  logic [7:0]  srcByte,
  input  logic        srcLast,
  input  logic        srcPrune,
  input  logic        srcAbort,
  input  logic        srcReady,
  output logic        pushValid,
  output token_t      pushTok
);

  localparam int LANE_W = $clog2(WORD_BYTES);

  logic [31:0]       accWord;
  logic [LANE_W-1:0] accCnt;
  logic [31:0]       newWord;
  logic              beatOk;

  assign beatOk = srcValid && srcReady;

  always_comb begin
    newWord = accWord;
    for (int i = 0; i < WORD_BYTES; i++) begin
      if (accCnt == LANE_W'(i)) newWord[8*(WORD_BYTES-1-i) +: 8] = srcByte;
    end
  end

  always_comb begin
    pushValid      = 1'b0;
    pushTok.kind   = TK_DATA;
    pushTok.unused = 2'd3 - 2'(accCnt);
    pushTok.data   = newWord;
    if (beatOk) begin
      if (srcAbort) begin
        pushValid    = 1'b1;
        pushTok.kind = TK_ABORT;
      end else if (srcLast) begin
        pushValid    = 1'b1;
        pushTok.kind = srcPrune ? TK_PRUNE : TK_LAST;
      end else if (accCnt == LANE_W'(WORD_BYTES-1)) begin
        pushValid    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accWord <= '0;
      accCnt  <= '0;
    end else if (beatOk) begin
      if (srcAbort || srcLast || accCnt == LANE_W'(WORD_BYTES-1)) begin
        accWord <= '0;
        accCnt  <= '0;
      end else begin
        accWord <= newWord;
        accCnt  <= accCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/xtr_enc_datapath.sv
module xtr_enc_datapath
  import xtr_enc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        srcValid,
  input  logic [7:0]  srcByte,
  input  logic        srcLast,
  input  logic        srcPrune,
  input  logic        srcAbort,
  output logic        srcReady,
  input  logic        cfgSwap,
  input  ctrlStrobe_t strobe,
  output tokKind_t    headKind,
  output logic        headEsc,
  output logic        empty,
  output logic [31:0] rdData,
  output logic        dataPresent
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  token_t             mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [CNT_W-1:0]   count;
  logic               pushValid;
  token_t             pushTok;
  token_t             headTok;
  logic [31:0]        swapped;
  logic [31:0]        presented;

  xtr_enc_packer #(.WORD_BYTES(4)) uPacker (
    .clk      (clk),
    .rstN     (rstN),
    .srcValid (srcValid),
    .srcByte  (srcByte),
    .srcLast  (srcLast),
    .srcPrune (srcPrune),
    .srcAbort (srcAbort),
    .srcReady (srcReady),
    .pushValid(pushValid),
    .pushTok  (pushTok)
  );

  assign srcReady    = (count != CNT_W'(DEPTH));
  assign empty       = (count == '0);
  assign dataPresent = !empty;
  assign headTok     = mem[rdPtr];
  assign headKind    = headTok.kind;

  always_ff @(posedge clk) begin
    if (pushValid) mem[wrPtr] <= pushTok;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushValid) wrPtr <= (wrPtr == PTR_W'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (strobe.pop) rdPtr <= (rdPtr == PTR_W'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      case ({pushValid, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  for (genvar i = 0; i < 4; i++) begin : gLane
    assign swapped[8*i +: 8] = headTok.data[8*(3-i) +: 8];
  end

  assign presented = cfgSwap ? swapped : headTok.data;
  assign headEsc   = (presented[31:3] == CODE_ESC[31:3]);

  always_comb begin
    unique case (strobe.sel)
      SEL_DATA:   rdData = presented;
      SEL_ESC:    rdData = CODE_ESC;
      SEL_EOF:    rdData = {CODE_EOF[31:2], headTok.unused};
      SEL_PRUNED: rdData = CODE_PRUNED;
      SEL_ABORT:  rdData = CODE_ABORT;
      default:    rdData = CODE_NOTRDY;
    endcase
  end

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (count == CNT_W'(DEPTH)) |-> !pushValid);

  a_r9_pop_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> (count != '0));

  a_r3_empty_notready: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> (rdData == CODE_NOTRDY));

endmodule

// File: rtl/xtr_enc_control.sv
module xtr_enc_control
  import xtr_enc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdStrobe,
  input  logic        empty,
  input  tokKind_t    headKind,
  input  logic        headEsc,
  output ctrlStrobe_t strobe
);

  typedef enum logic [1:0] {PH_FIRST, PH_DATA, PH_EOF} phase_t;

  phase_t phase, nextPhase;

  always_comb begin
    strobe.pop = 1'b0;
    strobe.sel = SEL_NOTRDY;
    nextPhase  = phase;
    if (!empty) begin
      unique case (phase)
        PH_FIRST: begin
          unique case (headKind)
            TK_ABORT: begin
              strobe.sel = SEL_ABORT;
              strobe.pop = rdStrobe;
            end
            TK_PRUNE: begin
              strobe.sel = SEL_PRUNED;
              if (rdStrobe) nextPhase = PH_DATA;
            end
            default: begin
              if (headEsc) begin
                strobe.sel = SEL_ESC;
                if (rdStrobe) nextPhase = PH_DATA;
              end else begin
                strobe.sel = SEL_DATA;
                if (rdStrobe) begin
                  if (headKind == TK_LAST) nextPhase = PH_EOF;
                  else strobe.pop = 1'b1;
                end
              end
            end
          endcase
        end
        PH_DATA: begin
          strobe.sel = SEL_DATA;
          if (rdStrobe) begin
            if (headKind == TK_LAST) nextPhase = PH_EOF;
            else begin
              strobe.pop = 1'b1;
              nextPhase  = PH_FIRST;
            end
          end
        end
        default: begin
          strobe.sel = SEL_EOF;
          if (rdStrobe) begin
            strobe.pop = 1'b1;
            nextPhase  = PH_FIRST;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_FIRST;
    else       phase <= nextPhase;
  end

  a_r5_esc_then_data: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && strobe.sel == SEL_ESC) |=> (strobe.sel == SEL_DATA));

  a_r6_pruned_then_word: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && strobe.sel == SEL_PRUNED) |=> (strobe.sel == SEL_DATA));

  a_r4_eof_on_last: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_EOF) |-> (!empty && headKind == TK_LAST));

  a_r3_empty_holds: assert property (@(posedge clk) disable iff (!rstN)
    (empty && rdStrobe) |=> $stable(phase));

endmodule

// File: rtl/xtr_word_encoder.sv
module xtr_word_encoder
  import xtr_enc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        srcValid,
  input  logic [7:0]  srcByte,
  input  logic        srcLast,
  input  logic        srcPrune,
  input  logic        srcAbort,
  output logic        srcReady,
  input  logic        cfgSwap,
  input  logic        rdStrobe,
  output logic [31:0] rdData,
  output logic        dataPresent
);

  ctrlStrobe_t strobe;
  tokKind_t    headKind;
  logic        headEsc;
  logic        empty;

  xtr_enc_datapath #(.DEPTH(DEPTH)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .srcValid   (srcValid),
    .srcByte    (srcByte),
    .srcLast    (srcLast),
    .srcPrune   (srcPrune),
    .srcAbort   (srcAbort),
    .srcReady   (srcReady),
    .cfgSwap    (cfgSwap),
    .strobe     (strobe),
    .headKind   (headKind),
    .headEsc    (headEsc),
    .empty      (empty),
    .rdData     (rdData),
    .dataPresent(dataPresent)
  );

  xtr_enc_control uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .rdStrobe(rdStrobe),
    .empty   (empty),
    .headKind(headKind),
    .headEsc (headEsc),
    .strobe  (strobe)
  );

  a_r7_abort_consumed: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rdData == CODE_ABORT && strobe.sel == SEL_ABORT) |-> strobe.pop);

endmodule

// File: tb/xtr_word_encoder_test.sv
module xtr_word_encoder_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EOF0   = 32'h8000_0000;
  localparam logic [31:0] PRUNED = 32'h8000_0004;
  localparam logic [31:0] ABORT  = 32'h8000_0005;
  localparam logic [31:0] ESC    = 32'h8000_0006;
  localparam logic [31:0] NOTRDY = 32'h8000_0007;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        srcValid = 1'b0;
  logic [7:0]  srcByte = '0;
  logic        srcLast = 1'b0, srcPrune = 1'b0, srcAbort = 1'b0;
  logic        srcReady;
  logic        cfgSwap = 1'b0;
  logic        rdStrobe = 1'b0;
  logic [31:0] rdData;
  logic        dataPresent;

  int errors = 0;
  int checks = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  xtr_word_encoder uut (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcByte(srcByte),
    .srcLast(srcLast), .srcPrune(srcPrune), .srcAbort(srcAbort),
    .srcReady(srcReady), .cfgSwap(cfgSwap), .rdStrobe(rdStrobe),
    .rdData(rdData), .dataPresent(dataPresent)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] present(input logic [31:0] w, input bit swap);
    return swap ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
  endfunction

  function automatic void expData(input logic [31:0] w, input bit swap, input string tag);
    logic [31:0] p = present(w, swap);
    if (p[31:3] == 29'h1000_0000) begin
      expQ.push_back(ESC); tagQ.push_back("R5");
    end
    expQ.push_back(p); tagQ.push_back(tag);
  endfunction

  // kind: 0 normal end, 1 pruned end, 2 abort beat after the bytes
  function automatic void buildExp(input logic [7:0] b[$], input int kind, input bit swap);
    int n = b.size();
    int groups = (kind == 2) ? n / 4 : (n + 3) / 4;
    for (int g = 0; g < groups; g++) begin
      logic [31:0] w = '0;
      int valid = 0;
      for (int k = 0; k < 4; k++) begin
        if (g*4 + k < n) begin
          w[8*(3-k) +: 8] = b[g*4 + k];
          valid++;
        end
      end
      if (g == groups - 1 && kind == 1) begin
        expQ.push_back(PRUNED); tagQ.push_back("R6");
        expQ.push_back(present(w, swap)); tagQ.push_back("R6");
      end else begin
        expData(w, swap, swap ? "R8" : "R2");
        if (g == groups - 1 && kind == 0) begin
          expQ.push_back(EOF0 | 32'((4 - valid) % 4)); tagQ.push_back("R4");
        end
      end
    end
    if (kind == 2) begin
      expQ.push_back(ABORT); tagQ.push_back("R7");
    end
  endfunction

  task automatic beat(input logic [7:0] b, input bit l, input bit p, input bit a);
    bit ok;
    srcByte = b; srcLast = l; srcPrune = p; srcAbort = a; srcValid = 1'b1;
    forever begin
      ok = srcReady;
      @(posedge clk);
      @(negedge clk);
      if (ok) break;
    end
    srcValid = 1'b0; srcLast = 1'b0; srcPrune = 1'b0; srcAbort = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] b[$], input int kind);
    for (int i = 0; i < b.size(); i++) begin
      bit l = (kind != 2) && (i == b.size() - 1);
      beat(b[i], l, l && (kind == 1), 1'b0);
    end
    if (kind == 2) beat(8'h00, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic readAll();
    while (expQ.size() > 0) begin
      string t = tagQ.pop_front();
      check("R9 present", 32'(dataPresent), 32'd1);
      check(t, rdData, expQ.pop_front());
      rdStrobe = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rdStrobe = 1'b0;
    end
    check("R9 drained", 32'(dataPresent), 32'd0);
    check("R3 idle code", rdData, NOTRDY);
  endtask

  task automatic frame(input logic [7:0] b[$], input int kind, input bit swap);
    cfgSwap = swap;
    buildExp(b, kind, swap);
    sendFrame(b, kind);
    readAll();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 present", 32'(dataPresent), 32'd0);
    check("R1 ready", 32'(srcReady), 32'd1);
    check("R1 code", rdData, NOTRDY);
    // R3 reads on empty consume nothing
    for (int i = 0; i < 3; i++) begin
      check("R3 empty read", rdData, NOTRDY);
      rdStrobe = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rdStrobe = 1'b0;
      check("R3 still empty", 32'(dataPresent), 32'd0);
    end
    // R2/R4 eight bytes, full last word
    frame('{8'h01,8'h02,8'h03,8'h04,8'h05,8'h06,8'h07,8'h08}, 0, 1'b0);
    // R4 each partial last lane
    frame('{8'h11,8'h12,8'h13,8'h14,8'h15,8'h16}, 0, 1'b0);
    frame('{8'h21}, 0, 1'b0);
    frame('{8'h31,8'h32,8'h33}, 0, 1'b0);
    // R5 colliding word, and colliding last word
    frame('{8'h80,8'h00,8'h00,8'h05,8'hAA}, 0, 1'b0);
    frame('{8'h80,8'h00,8'h00,8'h07}, 0, 1'b0);
    // R6 pruned ends, including a colliding final word (no escape)
    frame('{8'h41,8'h42,8'h43,8'h44,8'h45,8'h46,8'h47}, 1, 1'b0);
    frame('{8'h80,8'h00,8'h00,8'h01}, 1, 1'b0);
    // R7 abort with a partial word pending, and with none
    frame('{8'h51,8'h52,8'h53,8'h54,8'h55}, 2, 1'b0);
    frame('{8'h61,8'h62,8'h63,8'h64}, 2, 1'b0);
    // R8 swapped output
    frame('{8'h01,8'h02,8'h03,8'h04,8'h05}, 0, 1'b1);
    frame('{8'h05,8'h00,8'h00,8'h80,8'h77,8'h78}, 0, 1'b1);
    frame('{8'h80,8'h00,8'h00,8'h05}, 0, 1'b1);
    frame('{8'h71,8'h72,8'h73,8'h74,8'h75}, 1, 1'b1);
    // R10 frame longer than the queue, read concurrently
    begin
      logic [7:0] big[$];
      for (int i = 0; i < 24; i++) big.push_back(8'(8'h20 + i));
      cfgSwap = 1'b0;
      buildExp(big, 0, 1'b0);
      fork
        sendFrame(big, 0);
      join_none
      repeat (30) @(negedge clk);
      check("R10 stalled", 32'(srcReady), 32'd0);
      check("R10 present", 32'(dataPresent), 32'd1);
      while (expQ.size() > 0) begin
        if (rdData != NOTRDY) begin
          string t = tagQ.pop_front();
          check({t, " R10"}, rdData, expQ.pop_front());
          rdStrobe = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        rdStrobe = 1'b0;
      end
      wait fork;
      @(negedge clk);
      check("R10 drained", 32'(dataPresent), 32'd0);
      check("R10 ready", 32'(srcReady), 32'd1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule